// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of address translations. Each entry maps a virtual page to a physical frame. It also stores the identifier of the process that owns the mapping, a page size code, and write and execute permissions. Because each entry carries its owner's identifier, translations from several processes can stay resident together, so a context switch does not have to discard them. An entry may describe a normal 4 KB page or a larger 2 MB or 1 GB region. For the larger sizes, only the upper address bits are compared, and the remaining low bits pass straight through into the physical address.

A lookup presents a virtual address, the current process identifier and the access type (store or instruction fetch). One cycle later the block reports exactly one of three results: hit with a physical address, miss, or permission fault. After a miss, refill logic (software or a table walker) writes the translation through the fill port. A targeted invalidate removes the mapping for one page of one process, for use when its permissions change. A flush command empties the whole structure at once.

Top module: `ptlb_top`

## Requirements
- R1: While reset is held, `rsp_valid` is 0. After reset every entry is empty, so every lookup reports a miss with `rsp_paddr` equal to 0.
- R2: A lookup presented in cycle t produces `rsp_valid` = 1 in cycle t+1 and in no other cycle. A cycle with no lookup produces `rsp_valid` = 0 one cycle later.
- R3: A lookup hits a 4 KB entry (size code 0) when its address bits [31:12] equal the stored tag. The reported address is then {frame, vaddr[11:0]}.
- R4: A lookup hits only an entry whose stored process identifier equals `lk_pid`. An entry with a matching page but a different identifier gives a miss.
- R5: A 2 MB entry (size code 1) compares only address bits [31:21]. Its physical address is the frame's bits [19:9] followed by vaddr[20:0].
- R6: A 1 GB entry (size code 2) compares only address bits [31:30]. Its physical address is the frame's bits [19:18] followed by vaddr[29:0]. Size code 3 behaves as 4 KB.
- R7: A store that hits an entry whose write bit is clear, or a fetch that hits an entry whose execute bit is clear, reports a fault instead of a hit or a miss. A fault and a miss both give `rsp_paddr` equal to 0.
- R8: Whenever `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. When `rsp_valid` is 0, all three are 0.
- R9: An invalidate clears every entry that matches its page and process identifier, using each entry's own size. Entries belonging to other pages or other processes are kept.
- R10: A flush clears every entry in a single cycle.
- R11: A fill whose page, size and process identifier equal those of an existing entry overwrites that entry in place and does not use a second slot.
- R12: A fill that matches no existing entry goes to the lowest-numbered empty slot. When no slot is empty, it goes to a round-robin victim that starts at slot 0 after reset and advances by one on each such eviction.
- R13: In a given cycle, a flush takes priority over an invalidate, and an invalidate over a fill; the lower-priority command is dropped. A lookup in that same cycle sees the contents as they were before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_pid | input | PID_W | Current process identifier |
| lk_store | input | 1 | Lookup is a store |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| fill_valid | input | 1 | Write a translation |
| fill_vpage | input | VA_W-12 | Virtual page number of the fill |
| fill_pid | input | PID_W | Owner process of the fill |
| fill_size | input | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_frame | input | PA_W-12 | Physical frame number |
| fill_wr | input | 1 | Stores allowed |
| fill_ex | input | 1 | Fetches allowed |
| inv_valid | input | 1 | Invalidate one page of one process |
| inv_vpage | input | VA_W-12 | Page number to purge |
| inv_pid | input | PID_W | Process whose mapping is purged |
| flush_all | input | 1 | Clear all entries |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry forbids the access |
| rsp_paddr | output | PA_W | Translated physical address |

## Verification
The bench uses the default parameters: 32-bit virtual and physical addresses, 8-bit process identifiers and eight entries. With eight entries, a dozen fills are enough to fill every slot and to drive the round-robin pointer through several evictions, including an empty slot that reopens after the structure has been full. The 32-bit address width puts the 2 MB and 1 GB boundaries at bits 21 and 30. Lookups placed just inside and just outside each superpage can therefore confirm the size-dependent compare and the address pass-through.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    localparam int BASE_SHIFT = 12;
    localparam int MID_SHIFT  = 21;
    localparam int TOP_SHIFT  = 30;

    // untranslated low-order bits for a given page size
    function automatic int offset_bits(pg_size_e s);
        case (s)
            PG_2M:   return MID_SHIFT;
            PG_1G:   return TOP_SHIFT;
            default: return BASE_SHIFT;
        endcase
    endfunction

endpackage

// File: rtl/ptlb_cmp.sv
module ptlb_cmp
    import ptlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PID_W = 8
) (
    input  logic             e_vld,
    input  logic [VPN_W-1:0] e_tag,
    input  logic [PID_W-1:0] e_pid,
    input  pg_size_e         e_size,
    input  logic [VPN_W-1:0] q_vpn,
    input  logic [PID_W-1:0] q_pid,
    input  logic             q_exact,
    input  pg_size_e         q_size,
    output logic             match
);
    pg_size_e         cmp_size;
    logic [VPN_W-1:0] tag_mask;

    always_comb begin
        cmp_size = q_exact ? q_size : e_size;
        case (cmp_size)
            PG_2M:   tag_mask = {VPN_W{1'b1}} << (MID_SHIFT - BASE_SHIFT);
            PG_1G:   tag_mask = {VPN_W{1'b1}} << (TOP_SHIFT - BASE_SHIFT);
            default: tag_mask = {VPN_W{1'b1}};
        endcase
        match = e_vld && (e_pid == q_pid)
                && (((e_tag ^ q_vpn) & tag_mask) == '0)
                && (!q_exact || (e_size == q_size));
    end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    input  logic               go,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] rr_d, rr_q;
    logic             use_rr;

    always_comb begin
        idx    = rr_q;
        use_rr = 1'b0;
        if (|dup_vec) begin
            for (int i = ENTRIES - 1; i >= 0; i--)
                if (dup_vec[i]) idx = IDX_W'(i);
        end else if (~vld_vec != '0) begin
            for (int i = ENTRIES - 1; i >= 0; i--)
                if (!vld_vec[i]) idx = IDX_W'(i);
        end else begin
            use_rr = 1'b1;
        end
        rr_d = rr_q;
        if (go && use_rr)
            rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    // R12: a free slot is always taken before any live entry is evicted
    a_r12_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (go && dup_vec == '0 && ~vld_vec != '0) |-> !vld_vec[idx]);

    // R11: an exact duplicate is always the slot that is rewritten
    a_r11_dup_target: assert property (@(posedge clk) disable iff (!rst_n)
        (go && dup_vec != '0) |-> dup_vec[idx]);
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PID_W   = 8,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = VA_W - BASE_SHIFT,
    localparam int PFN_W  = PA_W - BASE_SHIFT,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_store,
    input  logic             lk_fetch,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpage,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [1:0]       fill_size,
    input  logic [PFN_W-1:0] fill_frame,
    input  logic             fill_wr,
    input  logic             fill_ex,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpage,
    input  logic [PID_W-1:0] inv_pid,
    input  logic             flush_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] tag;
        logic [PID_W-1:0] pid;
        pg_size_e         size;
        logic [PFN_W-1:0] pfn;
        logic             wr;
        logic             ex;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic               rv;
        logic               rh;
        logic               rm;
        logic               rf;
        logic [PA_W-1:0]    pa;
    } st_t;

    st_t st_d, st_q;

    logic [ENTRIES-1:0] lk_hv, inv_hv, dup_hv, vld_vec;
    logic [IDX_W-1:0]   vic_idx;
    logic               fill_go;
    pg_size_e           fsize;

    assign fsize   = pg_size_e'(fill_size);
    assign fill_go = fill_valid && !flush_all && !inv_valid;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign vld_vec[g] = st_q.ent[g].vld;

        ptlb_cmp #(.VPN_W(VPN_W), .PID_W(PID_W)) u_lk (
            .e_vld(st_q.ent[g].vld), .e_tag(st_q.ent[g].tag),
            .e_pid(st_q.ent[g].pid), .e_size(st_q.ent[g].size),
            .q_vpn(lk_vaddr[VA_W-1:BASE_SHIFT]), .q_pid(lk_pid),
            .q_exact(1'b0), .q_size(PG_4K), .match(lk_hv[g]));

        ptlb_cmp #(.VPN_W(VPN_W), .PID_W(PID_W)) u_inv (
            .e_vld(st_q.ent[g].vld), .e_tag(st_q.ent[g].tag),
            .e_pid(st_q.ent[g].pid), .e_size(st_q.ent[g].size),
            .q_vpn(inv_vpage), .q_pid(inv_pid),
            .q_exact(1'b0), .q_size(PG_4K), .match(inv_hv[g]));

        ptlb_cmp #(.VPN_W(VPN_W), .PID_W(PID_W)) u_dup (
            .e_vld(st_q.ent[g].vld), .e_tag(st_q.ent[g].tag),
            .e_pid(st_q.ent[g].pid), .e_size(st_q.ent[g].size),
            .q_vpn(fill_vpage), .q_pid(fill_pid),
            .q_exact(1'b1), .q_size(fsize), .match(dup_hv[g]));
    end

    ptlb_victim #(.ENTRIES(ENTRIES)) u_vic (
        .clk(clk), .rst_n(rst_n), .vld_vec(vld_vec), .dup_vec(dup_hv),
        .go(fill_go), .idx(vic_idx));

    logic [IDX_W-1:0] sel;
    ent_t             hit_e;
    logic             any_hit, perm_bad;
    logic [PA_W-1:0]  off_mask, xl_pa;

    always_comb begin
        st_d = st_q;

        // lookup against the pre-update contents, lowest slot wins
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (lk_hv[i]) sel = IDX_W'(i);
        hit_e    = st_q.ent[sel];
        any_hit  = |lk_hv;
        perm_bad = (lk_store && !hit_e.wr) || (lk_fetch && !hit_e.ex);
        off_mask = (PA_W'(1) << offset_bits(hit_e.size)) - PA_W'(1);
        xl_pa    = ({hit_e.pfn, {BASE_SHIFT{1'b0}}} & ~off_mask)
                 | (PA_W'(lk_vaddr) & off_mask);

        st_d.rv = lk_valid;
        st_d.rh = lk_valid && any_hit && !perm_bad;
        st_d.rf = lk_valid && any_hit && perm_bad;
        st_d.rm = lk_valid && !any_hit;
        st_d.pa = (lk_valid && any_hit && !perm_bad) ? xl_pa : '0;

        // table update: flush > invalidate > fill
        if (flush_all) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
        end else if (inv_valid) begin
            for (int i = 0; i < ENTRIES; i++)
                if (inv_hv[i]) st_d.ent[i].vld = 1'b0;
        end else if (fill_valid) begin
            st_d.ent[vic_idx].vld  = 1'b1;
            st_d.ent[vic_idx].tag  = fill_vpage;
            st_d.ent[vic_idx].pid  = fill_pid;
            st_d.ent[vic_idx].size = fsize;
            st_d.ent[vic_idx].pfn  = fill_frame;
            st_d.ent[vic_idx].wr   = fill_wr;
            st_d.ent[vic_idx].ex   = fill_ex;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.rh;
    assign rsp_miss  = st_q.rm;
    assign rsp_fault = st_q.rf;
    assign rsp_paddr = st_q.pa;

    // R2: one-cycle result latency
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R8: result classification is exclusive
    a_r8_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault} == 3'b000));
    // R7: no address escapes on a fault or miss
    a_r7_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_miss) |-> (rsp_paddr == '0));
    // R10: flush empties the table in one cycle
    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_vec == '0));
endmodule

// File: tb/ptlb_top_tb.sv
module ptlb_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_store = 0, lk_fetch = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        fill_valid = 0, fill_wr = 0, fill_ex = 0;
    logic [19:0] fill_vpage = '0, fill_frame = '0;
    logic [7:0]  fill_pid = '0;
    logic [1:0]  fill_size = '0;
    logic        inv_valid = 0;
    logic [19:0] inv_vpage = '0;
    logic [7:0]  inv_pid = '0;
    logic        flush_all = 0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptlb_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_store(lk_store), .lk_fetch(lk_fetch),
        .fill_valid(fill_valid), .fill_vpage(fill_vpage), .fill_pid(fill_pid),
        .fill_size(fill_size), .fill_frame(fill_frame),
        .fill_wr(fill_wr), .fill_ex(fill_ex),
        .inv_valid(inv_valid), .inv_vpage(inv_vpage), .inv_pid(inv_pid),
        .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr));

    typedef enum int {K_HIT, K_MISS, K_FAULT} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] pa;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic chk(string req, bit ok, string act, string expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    // monitor: R8 classification and address compared against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk("R2", 1'b0, "unexpected rsp_valid", "idle");
            end else begin
                exp_t e;
                bit   ok;
                e  = sb_q.pop_front();
                ok = (rsp_hit == (e.kind == K_HIT)) && (rsp_miss == (e.kind == K_MISS))
                     && (rsp_fault == (e.kind == K_FAULT)) && (rsp_paddr == e.pa);
                chk(e.req, ok,
                    $sformatf("h%0b m%0b f%0b pa=%h", rsp_hit, rsp_miss, rsp_fault, rsp_paddr),
                    $sformatf("%s pa=%h", e.kind.name(), e.pa));
            end
        end
    end

    task automatic start();
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        lk_valid = 0; lk_store = 0; lk_fetch = 0;
        fill_valid = 0; inv_valid = 0; flush_all = 0;
    endtask

    task automatic drv_lk(logic [31:0] va, logic [7:0] pid, bit st, bit fe,
                          kind_e k, logic [31:0] pa, string req);
        exp_t e;
        lk_valid = 1; lk_vaddr = va; lk_pid = pid; lk_store = st; lk_fetch = fe;
        e.kind = k; e.pa = pa; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic drv_fill(logic [19:0] vp, logic [7:0] pid, logic [1:0] sz,
                            logic [19:0] fr, bit wr, bit ex);
        fill_valid = 1; fill_vpage = vp; fill_pid = pid; fill_size = sz;
        fill_frame = fr; fill_wr = wr; fill_ex = ex;
    endtask

    task automatic drv_inv(logic [19:0] vp, logic [7:0] pid);
        inv_valid = 1; inv_vpage = vp; inv_pid = pid;
    endtask

    task automatic lookup(logic [31:0] va, logic [7:0] pid, bit st, bit fe,
                          kind_e k, logic [31:0] pa, string req);
        start(); drv_lk(va, pid, st, fe, k, pa, req); step();
    endtask

    task automatic fill(logic [19:0] vp, logic [7:0] pid, logic [1:0] sz,
                        logic [19:0] fr, bit wr, bit ex);
        start(); drv_fill(vp, pid, sz, fr, wr, ex); step();
    endtask

    task automatic inval(logic [19:0] vp, logic [7:0] pid);
        start(); drv_inv(vp, pid); step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk("watchdog", 1'b0, "timeout", "finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", rsp_valid == 1'b0, $sformatf("%0b", rsp_valid), "0");
        rst_n = 1'b1;

        // R1: empty after reset
        lookup(32'h1234_5678, 8'd1, 0, 0, K_MISS, 32'h0, "R1");

        // R3 / R4: 4 KB translations and process tagging
        fill(20'h00005, 8'd1, 2'd0, 20'h000AB, 1, 0);
        lookup(32'h0000_5123, 8'd1, 0, 0, K_HIT,  32'h000A_B123, "R3");
        lookup(32'h0000_5123, 8'd2, 0, 0, K_MISS, 32'h0,         "R4");
        lookup(32'h0000_6123, 8'd1, 0, 0, K_MISS, 32'h0,         "R3");

        // R2: bubble cycle produces no response
        @(negedge clk); @(negedge clk);
        chk("R2", rsp_valid == 1'b0, $sformatf("%0b", rsp_valid), "0");

        // R7: permissions
        lookup(32'h0000_5010, 8'd1, 1, 0, K_HIT,   32'h000A_B010, "R7");
        lookup(32'h0000_5010, 8'd1, 0, 1, K_FAULT, 32'h0,         "R7");
        fill(20'h00007, 8'd1, 2'd0, 20'h000CD, 0, 1);
        lookup(32'h0000_7044, 8'd1, 1, 0, K_FAULT, 32'h0,         "R7");
        lookup(32'h0000_7044, 8'd1, 0, 1, K_HIT,   32'h000C_D044, "R7");

        // R5: 2 MB superpage, frame low bits ignored
        fill(20'h00400, 8'd3, 2'd1, 20'h12345, 1, 1);
        lookup(32'h0045_6789, 8'd3, 0, 0, K_HIT,  32'h1225_6789, "R5");
        lookup(32'h0065_6789, 8'd3, 0, 0, K_MISS, 32'h0,         "R5");

        // R6: 1 GB superpage
        fill(20'h80000, 8'd4, 2'd2, 20'h40000, 1, 1);
        lookup(32'hBFFF_FFFC, 8'd4, 0, 0, K_HIT,  32'h7FFF_FFFC, "R6");
        lookup(32'hC000_0000, 8'd4, 0, 0, K_MISS, 32'h0,         "R6");

        // R11: duplicate overwrite; R4: same page, other process coexists
        fill(20'h00005, 8'd1, 2'd0, 20'h000EE, 1, 1);
        fill(20'h00005, 8'd2, 2'd0, 20'h00111, 1, 1);
        lookup(32'h0000_5123, 8'd1, 0, 0, K_HIT, 32'h000E_E123, "R11");
        lookup(32'h0000_5123, 8'd2, 0, 0, K_HIT, 32'h0011_1123, "R4");

        // R9: targeted purge
        inval(20'h00005, 8'd2);
        lookup(32'h0000_5123, 8'd2, 0, 0, K_MISS, 32'h0,         "R9");
        lookup(32'h0000_5123, 8'd1, 0, 0, K_HIT,  32'h000E_E123, "R9");
        lookup(32'h0000_7044, 8'd1, 0, 1, K_HIT,  32'h000C_D044, "R9");

        // R12: fill to capacity, then round-robin from slot 0
        fill(20'h00010, 8'd5, 2'd0, 20'h00101, 1, 1);
        fill(20'h00011, 8'd5, 2'd0, 20'h00102, 1, 1);
        fill(20'h00012, 8'd5, 2'd0, 20'h00103, 1, 1);
        fill(20'h00013, 8'd5, 2'd0, 20'h00104, 1, 1);
        fill(20'h00014, 8'd5, 2'd0, 20'h00105, 1, 1);
        lookup(32'h0000_5123, 8'd1, 0, 0, K_MISS, 32'h0,         "R12");
        lookup(32'h0001_4008, 8'd5, 0, 0, K_HIT,  32'h0010_5008, "R12");
        lookup(32'h0000_7044, 8'd1, 0, 1, K_HIT,  32'h000C_D044, "R12");
        fill(20'h00015, 8'd5, 2'd0, 20'h00106, 1, 1);
        lookup(32'h0000_7044, 8'd1, 0, 1, K_MISS, 32'h0,         "R12");
        lookup(32'h0045_6789, 8'd3, 0, 0, K_HIT,  32'h1225_6789, "R12");
        inval(20'h00010, 8'd5);
        fill(20'h00016, 8'd5, 2'd0, 20'h00107, 1, 1);
        lookup(32'h0045_6789, 8'd3, 0, 0, K_HIT,  32'h1225_6789, "R12");
        fill(20'h00017, 8'd5, 2'd0, 20'h00108, 1, 1);
        lookup(32'h0045_6789, 8'd3, 0, 0, K_MISS, 32'h0,         "R12");
        lookup(32'hBFFF_FFFC, 8'd4, 0, 0, K_HIT,  32'h7FFF_FFFC, "R12");
        lookup(32'h0001_6ABC, 8'd5, 0, 0, K_HIT,  32'h0010_7ABC, "R12");

        // R13: invalidate beats fill in the same cycle
        start(); drv_inv(20'h80000, 8'd4); drv_fill(20'h00020, 8'd6, 2'd0, 20'h00200, 1, 1); step();
        lookup(32'hBFFF_FFFC, 8'd4, 0, 0, K_MISS, 32'h0, "R13");
        lookup(32'h0002_0000, 8'd6, 0, 0, K_MISS, 32'h0, "R13");

        // R13 / R10: lookup alongside flush sees old contents; flush clears all
        start(); drv_lk(32'h0001_1004, 8'd5, 0, 0, K_HIT, 32'h0010_2004, "R13"); drv_flush_fill(); step();
        lookup(32'h0001_1004, 8'd5, 0, 0, K_MISS, 32'h0, "R10");
        lookup(32'h0001_7000, 8'd5, 0, 0, K_MISS, 32'h0, "R10");
        lookup(32'h0003_0000, 8'd7, 0, 0, K_MISS, 32'h0, "R13");

        @(negedge clk); @(negedge clk);
        chk("R2", sb_q.size() == 0, $sformatf("%0d pending", sb_q.size()), "0 pending");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    task automatic drv_flush_fill();
        flush_all = 1;
        drv_fill(20'h00030, 8'd7, 2'd0, 20'h00300, 1, 1);
    endtask
endmodule